// File: doc/BRIEF.md
# Wide-Word Pack/Unpack Unit

This unit moves data between a 60-bit wide-word memory port and a local memory built from 16-bit cells that each carry a 12-bit value. In the read direction it accepts one wide word at a time and scatters it into five consecutive local cells. In the write direction it gathers five consecutive local cells and presents them as one wide word. A single start command sets the direction, the first local address, the number of wide words and the initial wide-memory address together with its addressing-mode flag. The unit then runs the whole block on its own and signals the end with a one-cycle done pulse.

The wide-word address is an 18-bit counter. It steps once per wide word. A mode flag follows it and selects between direct and relocated addressing. The flag flips each time a step changes the counter's top bit. The local address pointer runs on without a break from one wide word to the next and wraps modulo 4096. The unit does not arbitrate memory, add a relocation base or decode instructions.

Top module: `wide_pack_unit`

## Requirements
- R1: In the read direction, the 12-bit slices of an accepted wide word are written to local addresses d, d+1, d+2, d+3, d+4 in that order. Bits 59..48 go to d and bits 11..0 go to d+4, and every written cell has bits 15..12 equal to zero.
- R2: Bits 63..60 of an incoming wide word have no effect on any written cell.
- R3: Local addresses wrap from 0xFFF to 0x000. The second wide word of a block starts at d+5, the third at d+10, and so on.
- R4: In the write direction, cell d supplies bits 59..48 of the outgoing word and cell d+4 supplies bits 11..0. Bits 63..60 are zero, and bits 15..12 of each cell are ignored.
- R5: Exactly xfer_cnt wide words are transferred. A count of zero transfers nothing.
- R6: cm_addr is loaded at start, holds the address of the word in flight, and increments by one (modulo 2^18) after each wide word.
- R7: reloc is loaded at start and inverts whenever an increment changes bit 17 of cm_addr, including the wrap from 0x3FFFF to 0x00000.
- R8: done is high for exactly one cycle, in the cycle after the last wide word completes. With a count of zero it rises in the cycle after start.
- R9: A wide word is taken only on in_valid and in_ready. out_data and cm_addr stay stable while out_valid is high and out_ready is low.
- R10: start is ignored while a block is in progress.
- R11: Local reads return data one cycle after lm_rd. lm_rd and lm_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block (sampled when idle) |
| dir_wr | input | 1 | 0 = wide to local, 1 = local to wide |
| loc_base | input | 12 | First local address |
| xfer_cnt | input | 12 | Number of wide words |
| cm_addr_init | input | 18 | Initial wide-word address |
| reloc_init | input | 1 | Initial addressing-mode flag |
| cm_addr | output | 18 | Current wide-word address |
| reloc | output | 1 | Current mode flag (1 = relocated) |
| in_valid | input | 1 | Incoming wide word valid |
| in_data | input | 64 | Incoming wide word |
| in_ready | output | 1 | Unit can take a wide word |
| out_valid | output | 1 | Outgoing wide word valid |
| out_data | output | 64 | Outgoing wide word |
| out_ready | input | 1 | Receiver takes the outgoing word |
| lm_addr | output | 12 | Local memory address |
| lm_wr | output | 1 | Local write strobe |
| lm_wdata | output | 16 | Local write data |
| lm_rd | output | 1 | Local read strobe |
| lm_rdata | input | 16 | Local read data, one cycle after lm_rd |
| done | output | 1 | One-cycle completion pulse |

## Verification
Read blocks are run with wide words arriving back to back and with idle gaps between them. Comparing the two shows whether the handshake waits correctly and whether the pointer carries across words. Every incoming word has a nonzero top nibble, and the cells are preloaded with junk in their upper bits, so any leak from those bits shows up as a wrong value. Write blocks are run with out_ready always high, alternating and mostly low, which separates the stall hold from the packing order. Base addresses near 0xFFF, wide addresses near 0x1FFFF and 0x3FFFF, a zero count and a start pulse during a busy block cover the wrap, the mode flip, the empty block and the ignored command.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_SCATTER,
    S_GATHER,
    S_DRAIN,
    S_SEND,
    S_DONE
  } wpk_state_e;
endpackage

// File: rtl/wpk_cm_addr.sv
module wpk_cm_addr #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          load_reloc,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          reloc
);
  logic [AW-1:0] addr_q, addr_d;
  logic          rel_q, rel_d;
  logic          en;

  always_comb begin
    addr_d = addr_q;
    rel_d  = rel_q;
    if (load) begin
      addr_d = load_addr;
      rel_d  = load_reloc;
    end else if (step) begin
      addr_d = addr_q + 1'b1;
      rel_d  = rel_q ^ (addr_d[AW-1] ^ addr_q[AW-1]);
    end
  end

  assign en = load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rel_q  <= 1'b0;
    end else if (en) begin
      addr_q <= addr_d;
      rel_q  <= rel_d;
    end
  end

  assign addr  = addr_q;
  assign reloc = rel_q;
endmodule

// File: rtl/wpk_lane_ctr.sv
module wpk_lane_ctr #(
  parameter int LANES = 5,
  parameter int LAW   = 12,
  localparam int LW   = $clog2(LANES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [LAW-1:0] base,
  input  logic           step,
  output logic [LAW-1:0] ptr,
  output logic [LW-1:0]  lane,
  output logic           last
);
  logic [LAW-1:0] ptr_q, ptr_d;
  logic [LW-1:0]  lane_q, lane_d;
  logic           en;

  assign last = (lane_q == LW'(LANES - 1));

  always_comb begin
    ptr_d  = ptr_q;
    lane_d = lane_q;
    if (load) begin
      ptr_d  = base;
      lane_d = '0;
    end else if (step) begin
      ptr_d  = ptr_q + 1'b1;
      lane_d = last ? '0 : lane_q + 1'b1;
    end
  end

  assign en = load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      lane_q <= '0;
    end else if (en) begin
      ptr_q  <= ptr_d;
      lane_q <= lane_d;
    end
  end

  assign ptr  = ptr_q;
  assign lane = lane_q;
endmodule

// File: rtl/wpk_word_buf.sv
module wpk_word_buf #(
  parameter int NW    = 12,
  parameter int LANES = 5,
  parameter int WW    = 64,
  localparam int PW   = NW * LANES,
  localparam int LW   = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_wide,
  input  logic [WW-1:0] wide_in,
  input  logic          cap_en,
  input  logic [LW-1:0] cap_lane,
  input  logic [NW-1:0] cap_data,
  input  logic [LW-1:0] rd_lane,
  output logic [NW-1:0] slice,
  output logic [WW-1:0] wide_out
);
  logic [PW-1:0] held;
  logic          unused_top;

  assign unused_top = ^wide_in[WW-1:PW];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [NW-1:0] q, d;
    logic          en;
    assign en = load_wide | (cap_en && (cap_lane == LW'(g)));
    assign d  = load_wide ? wide_in[(LANES-1-g)*NW +: NW] : cap_data;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
    assign held[(LANES-1-g)*NW +: NW] = q;
  end

  always_comb begin
    slice = '0;
    for (int i = 0; i < LANES; i++)
      if (rd_lane == LW'(i)) slice = held[(LANES-1-i)*NW +: NW];
  end

  assign wide_out = {{(WW-PW){1'b0}}, held};
endmodule

// File: rtl/wide_pack_unit.sv
module wide_pack_unit
  import wpk_pkg::*;
#(
  parameter int NW    = 12,
  parameter int LANES = 5,
  parameter int CELL  = 16,
  parameter int WW    = 64,
  parameter int LAW   = 12,
  parameter int AW    = 18,
  parameter int CNTW  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            dir_wr,
  input  logic [LAW-1:0]  loc_base,
  input  logic [CNTW-1:0] xfer_cnt,
  input  logic [AW-1:0]   cm_addr_init,
  input  logic            reloc_init,
  output logic [AW-1:0]   cm_addr,
  output logic            reloc,
  input  logic            in_valid,
  input  logic [WW-1:0]   in_data,
  output logic            in_ready,
  output logic            out_valid,
  output logic [WW-1:0]   out_data,
  input  logic            out_ready,
  output logic [LAW-1:0]  lm_addr,
  output logic            lm_wr,
  output logic [CELL-1:0] lm_wdata,
  output logic            lm_rd,
  input  logic [CELL-1:0] lm_rdata,
  output logic            done
);
  localparam int LW = $clog2(LANES);

  wpk_state_e      state_q, state_d;
  logic [CNTW-1:0] rem_q, rem_d;
  logic            rd_pend_q;
  logic [LW-1:0]   rd_lane_q;
  logic            cm_load, cm_step, lane_load, lane_step, buf_load;
  logic [LW-1:0]   lane;
  logic            lane_last;
  logic [NW-1:0]   slice;
  logic            unused_hi;

  assign unused_hi = ^lm_rdata[CELL-1:NW];

  wpk_cm_addr #(.AW(AW)) u_cm (
    .clk(clk), .rst_n(rst_n), .load(cm_load), .load_addr(cm_addr_init),
    .load_reloc(reloc_init), .step(cm_step), .addr(cm_addr), .reloc(reloc)
  );

  wpk_lane_ctr #(.LANES(LANES), .LAW(LAW)) u_lane (
    .clk(clk), .rst_n(rst_n), .load(lane_load), .base(loc_base),
    .step(lane_step), .ptr(lm_addr), .lane(lane), .last(lane_last)
  );

  wpk_word_buf #(.NW(NW), .LANES(LANES), .WW(WW)) u_buf (
    .clk(clk), .rst_n(rst_n), .load_wide(buf_load), .wide_in(in_data),
    .cap_en(rd_pend_q), .cap_lane(rd_lane_q), .cap_data(lm_rdata[NW-1:0]),
    .rd_lane(lane), .slice(slice), .wide_out(out_data)
  );

  assign lm_wdata = {{(CELL-NW){1'b0}}, slice};

  always_comb begin
    state_d   = state_q;
    rem_d     = rem_q;
    cm_load   = 1'b0;
    cm_step   = 1'b0;
    lane_load = 1'b0;
    lane_step = 1'b0;
    buf_load  = 1'b0;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    lm_wr     = 1'b0;
    lm_rd     = 1'b0;
    done      = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        cm_load   = 1'b1;
        lane_load = 1'b1;
        rem_d     = xfer_cnt;
        if (xfer_cnt == '0) state_d = S_DONE;
        else                state_d = dir_wr ? S_GATHER : S_FETCH;
      end
      S_FETCH: begin
        in_ready = 1'b1;
        if (in_valid) begin
          buf_load = 1'b1;
          state_d  = S_SCATTER;
        end
      end
      S_SCATTER: begin
        lm_wr     = 1'b1;
        lane_step = 1'b1;
        if (lane_last) begin
          cm_step = 1'b1;
          rem_d   = rem_q - 1'b1;
          state_d = (rem_q == CNTW'(1)) ? S_DONE : S_FETCH;
        end
      end
      S_GATHER: begin
        lm_rd     = 1'b1;
        lane_step = 1'b1;
        if (lane_last) state_d = S_DRAIN;
      end
      S_DRAIN: state_d = S_SEND;
      S_SEND: begin
        out_valid = 1'b1;
        if (out_ready) begin
          cm_step = 1'b1;
          rem_d   = rem_q - 1'b1;
          state_d = (rem_q == CNTW'(1)) ? S_DONE : S_GATHER;
        end
      end
      S_DONE: begin
        done    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      rem_q     <= '0;
      rd_pend_q <= 1'b0;
      rd_lane_q <= '0;
    end else begin
      state_q   <= state_d;
      rem_q     <= rem_d;
      rd_pend_q <= lm_rd;
      if (lm_rd) rd_lane_q <= lane;
    end
  end
endmodule

// File: rtl/wpk_checker.sv
module wpk_checker #(
  parameter int NW    = 12,
  parameter int LANES = 5,
  parameter int CELL  = 16,
  parameter int WW    = 64,
  parameter int LAW   = 12,
  parameter int AW    = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [AW-1:0]   cm_addr,
  input logic            reloc,
  input logic            out_valid,
  input logic [WW-1:0]   out_data,
  input logic            out_ready,
  input logic [LAW-1:0]  lm_addr,
  input logic            lm_wr,
  input logic [CELL-1:0] lm_wdata,
  input logic            lm_rd,
  input logic            done
);
  a_r1_cell_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lm_wr |-> lm_wdata[CELL-1:NW] == '0);

  a_r4_wide_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[WW-1:NW*LANES] == '0);

  a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lm_wr && lm_rd));

  a_r3_addr_consec: assert property (@(posedge clk) disable iff (!rst_n)
    lm_wr |=> (!lm_wr || lm_addr == LAW'($past(lm_addr) + 1'b1)));

  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(cm_addr)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (cm_addr == $past(cm_addr) || cm_addr == AW'($past(cm_addr) + 1'b1)));

  a_r7_mode_flip: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((reloc ^ $past(reloc)) == (cm_addr[AW-1] ^ $past(cm_addr[AW-1]))));
endmodule

bind wide_pack_unit wpk_checker #(
  .NW(NW), .LANES(LANES), .CELL(CELL), .WW(WW), .LAW(LAW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cm_addr(cm_addr), .reloc(reloc),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .lm_addr(lm_addr), .lm_wr(lm_wr), .lm_wdata(lm_wdata), .lm_rd(lm_rd),
  .done(done)
);

// File: tb/sim_wide_pack_unit.sv
module sim_wide_pack_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, dir_wr, reloc_init, reloc;
  logic [11:0] loc_base, xfer_cnt, lm_addr;
  logic [17:0] cm_addr_init, cm_addr;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [63:0] in_data, out_data;
  logic        lm_wr, lm_rd, done;
  logic [15:0] lm_wdata, lm_rdata;

  logic [15:0] mem [4096];
  int nv = 0, nf = 0;
  int rdy_mode = 0, rcyc = 0;

  logic [11:0] wa_q[$];
  logic [15:0] wd_q[$];
  string       wt_q[$];
  logic [63:0] od_q[$];
  logic [17:0] oa_q[$];
  logic        or_q[$];
  string       ot_q[$];

  always #4 clk = ~clk;

  wide_pack_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr),
    .loc_base(loc_base), .xfer_cnt(xfer_cnt), .cm_addr_init(cm_addr_init),
    .reloc_init(reloc_init), .cm_addr(cm_addr), .reloc(reloc),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .lm_addr(lm_addr), .lm_wr(lm_wr), .lm_wdata(lm_wdata), .lm_rd(lm_rd),
    .lm_rdata(lm_rdata), .done(done)
  );

  always @(posedge clk) begin
    if (lm_wr) mem[lm_addr] <= lm_wdata;
    if (lm_rd) lm_rdata <= mem[lm_addr];
  end

  always @(negedge clk) begin
    rcyc++;
    case (rdy_mode)
      1:       out_ready = rcyc[0];
      2:       out_ready = (rcyc % 4 == 3);
      default: out_ready = 1'b1;
    endcase
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nv++;
    if (!ok) begin
      nf++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk); #3;
    if (rst_n) begin
      if (lm_wr && lm_rd) chk(0, "R11", "rd and wr together", 1, 0);
      if (lm_wr) begin
        if (wa_q.size() == 0) chk(0, "R5", "unexpected local write", {52'b0, lm_addr}, 0);
        else begin
          automatic logic [11:0] ea = wa_q.pop_front();
          automatic logic [15:0] ed = wd_q.pop_front();
          automatic string t = wt_q.pop_front();
          chk(lm_addr == ea, t, "write address", lm_addr, ea);
          chk(lm_wdata == ed, t, "write data", lm_wdata, ed);
        end
      end
      if (out_valid && out_ready) begin
        if (od_q.size() == 0) chk(0, "R5", "unexpected wide word", out_data, 0);
        else begin
          automatic logic [63:0] ed = od_q.pop_front();
          automatic logic [17:0] ea = oa_q.pop_front();
          automatic logic er = or_q.pop_front();
          automatic string t = ot_q.pop_front();
          chk(out_data == ed, t, "wide data", out_data, ed);
          chk(cm_addr == ea, "R6", "address with word", cm_addr, ea);
          chk(reloc == er, "R7", "mode with word", reloc, er);
        end
      end
    end
  end

  function automatic void step_model(inout logic [17:0] a, inout logic r);
    logic [17:0] n;
    n = a + 18'd1;
    if (n[17] != a[17]) r = ~r;
    a = n;
  endfunction

  function automatic logic [63:0] mkword(int s, int w);
    logic [63:0] m;
    m = 64'(s) * 64'h9E3779B97F4A7C15 + 64'(w) * 64'hD1B54A32D192ED03;
    return {4'hF ^ 4'(w), m[59:0]};
  endfunction

  task automatic do_start(bit wr, logic [11:0] base, logic [11:0] cnt, logic [17:0] cma, logic rm);
    @(negedge clk);
    start = 1'b1; dir_wr = wr; loc_base = base; xfer_cnt = cnt;
    cm_addr_init = cma; reloc_init = rm;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string req, int max_lat);
    int n;
    n = 0;
    while (1) begin
      #3;
      if (done) break;
      n++;
      if (n > 3000) begin chk(0, req, "done timeout", 0, 1); return; end
      @(negedge clk);
    end
    chk(n <= max_lat, "R8", "done latency", n, max_lat);
    @(negedge clk); #3;
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
  endtask

  task automatic end_check(string req, logic [17:0] ea, logic er);
    chk(cm_addr == ea, "R6", "final address", cm_addr, ea);
    chk(reloc == er, "R7", "final mode", reloc, er);
    chk(wa_q.size() == 0 && od_q.size() == 0, req, "all items seen",
        wa_q.size() + od_q.size(), 0);
  endtask

  task automatic run_read(int seed, logic [11:0] base, int cnt, logic [17:0] cma,
                          logic rm, int gap, bit hit, string req);
    logic [17:0] a = cma;
    logic r = rm;
    for (int w = 0; w < cnt; w++) begin
      logic [63:0] d = mkword(seed, w);
      for (int k = 0; k < 5; k++) begin
        wa_q.push_back(12'(base + 12'(5 * w + k)));
        wd_q.push_back({4'h0, d[59 - 12 * k -: 12]});
        wt_q.push_back(req);
      end
      step_model(a, r);
    end
    do_start(1'b0, base, 12'(cnt), cma, rm);
    for (int w = 0; w < cnt; w++) begin
      repeat (gap) @(negedge clk);
      in_valid = 1'b1;
      in_data  = mkword(seed, w);
      while (1) begin
        #3;
        if (in_ready) break;
        @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '1;
      if (hit && w == 0) begin
        start = 1'b1; dir_wr = 1'b1; xfer_cnt = 12'd7; loc_base = 12'h555;
        cm_addr_init = 18'h0AAAA; reloc_init = ~rm;
        @(negedge clk);
        start = 1'b0;
      end
    end
    wait_done(req, 8);
    end_check(req, a, r);
  endtask

  task automatic run_write(int seed, logic [11:0] base, int cnt, logic [17:0] cma,
                           logic rm, int mode, string req);
    logic [17:0] a = cma;
    logic r = rm;
    rdy_mode = mode;
    for (int w = 0; w < cnt; w++) begin
      logic [59:0] pk = '0;
      logic [63:0] m = mkword(seed, w);
      for (int k = 0; k < 5; k++) begin
        logic [15:0] c = {4'h8 | 4'(k), m[12 * k +: 12]};
        mem[12'(base + 12'(5 * w + k))] = c;
        pk[59 - 12 * k -: 12] = c[11:0];
      end
      od_q.push_back({4'h0, pk});
      oa_q.push_back(a);
      or_q.push_back(r);
      ot_q.push_back(req);
      step_model(a, r);
    end
    do_start(1'b1, base, 12'(cnt), cma, rm);
    wait_done(req, 200);
    end_check(req, a, r);
    rdy_mode = 0;
  endtask

  initial begin
    #(8 * 150000);
    nf++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nv, nf);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; dir_wr = 1'b0; loc_base = '0; xfer_cnt = '0;
    cm_addr_init = '0; reloc_init = 1'b0; in_valid = 1'b0; in_data = '0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #3;
    chk(!done && !in_ready && !out_valid && !lm_wr && !lm_rd, "R8", "reset outputs idle",
        {59'b0, done, in_ready, out_valid, lm_wr, lm_rd}, 0);
    chk(cm_addr == 18'd0 && reloc == 1'b0, "R6", "reset address", cm_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R2: single word, back-to-back arrival
    run_read(1, 12'h010, 1, 18'h00100, 1'b0, 0, 1'b0, "R1");
    // R3 R7: pointer wrap, word gaps, bit-17 crossing
    run_read(2, 12'hFFD, 3, 18'h1FFFF, 1'b0, 2, 1'b0, "R3");
    // R10: start while busy is ignored
    run_read(3, 12'h200, 3, 18'h00040, 1'b1, 1, 1'b1, "R10");
    // R4: gather with receiver always ready
    run_write(4, 12'h100, 2, 18'h01000, 1'b0, 0, "R4");
    // R9 R6 R7: alternating stall, 18-bit wrap
    run_write(5, 12'hFFE, 3, 18'h3FFFE, 1'b1, 1, "R9");
    // R9: mostly stalled receiver
    run_write(6, 12'h7F0, 2, 18'h12345, 1'b0, 2, "R9");
    // R5 R8: zero count in both directions
    do_start(1'b0, 12'h300, 12'd0, 18'h0BEEF, 1'b1);
    wait_done("R5", 0);
    end_check("R5", 18'h0BEEF, 1'b1);
    do_start(1'b1, 12'h300, 12'd0, 18'h2BEEF, 1'b0);
    wait_done("R5", 0);
    end_check("R5", 18'h2BEEF, 1'b0);
    // R2: mixed back-to-back longer read
    run_read(7, 12'h000, 4, 18'h1FFFD, 1'b1, 0, 1'b0, "R2");
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nv, nf);
    $finish;
  end
endmodule